// File: doc/BRIEF.md
# In-Order Five-Stage Pipeline Controller with Branch Stalls

This block is the control and occupancy logic for an in-order pipeline of five stages: instruction fetch, decode, operand fetch, execute and operand write. It keeps a valid bit and an instruction address tag for every stage, drives the fetch address to an instruction memory, and moves every stage's contents one stage forward on every clock. The memory answers each fetch in the same cycle with a two-bit class and a target address field.

There is no branch prediction. When a fetched word is a branch, fetch stops and the fetch slot stays empty until the branch reaches execute. In the execute cycle the branch is resolved. A jump is always taken. A conditional branch is taken when the `ex_cond` input is high in that cycle. The following fetch uses the target field if the branch is taken, or the branch address plus one if it is not. Every branch therefore costs exactly three bubbles. No wrong-path work ever enters the pipe, so nothing is ever squashed.

An end-of-program class marks the last instruction. After it is fetched, fetch stops for good. Once the pipe has drained, a done flag rises. A retired-instruction counter and a cycle counter are also brought out.

Top module: `branch_stall_pipe`

## Requirements
- R1: A synchronous reset clears every stage valid bit, `done`, `retire` and both counters. In the first cycle after reset is released, fetch is valid at address `START_ADDR` (default 0).
- R2: Without a branch, each fetch address is the previous one plus one. Every stage's valid bit and tag appear in the next stage one cycle later, from fetch (bit/field 0) through write (bit/field 4).
- R3: A fetch whose class is 2'b01 (conditional branch) or 2'b10 (jump) is followed by exactly three cycles with the fetch stage empty.
- R4: A jump, or a conditional branch with `ex_cond` high in its execute cycle (stage 3), makes the next fetch use that instruction's target field.
- R5: A conditional branch with `ex_cond` low in its execute cycle makes the next fetch use the branch address plus one, with the same three bubbles.
- R6: `ex_cond` has no effect in a cycle when the execute stage does not hold a valid branch.
- R7: `retire` is high exactly in cycles where the write stage holds a valid instruction, and `retire_tag` gives its address. Bubbles never retire. `retired_cnt` counts retirements, including the one in the current cycle.
- R8: After a fetch of class 2'b11 (end marker), nothing more is fetched. `done` rises once the pipe is empty and then stays high, and `cycle_cnt` stops counting.
- R9: `cycle_cnt` reads k in the k-th cycle after reset. Take a twelve-instruction program with a taken branch at the fourth instruction (address 3) to the ninth (address 8). Its last instruction retires with `cycle_cnt` equal to 15, which is 165 ns at an 11 ns cycle.
- R10: Every fetched instruction retires. The number of retirements equals the number of valid fetch cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | ADDR_W | Fetch address (fetch stage tag) |
| imem_cls | input | 2 | Class of the fetched word: 00 plain, 01 conditional branch, 10 jump, 11 end |
| imem_tgt | input | ADDR_W | Target field of the fetched word |
| ex_cond | input | 1 | Branch condition, read while a conditional branch is in execute |
| stg_valid | output | 5 | Valid bit per stage, bit 0 = fetch |
| stg_tag | output | 5*ADDR_W | Address tag per stage, field 0 = fetch |
| retire | output | 1 | Write stage holds a valid instruction |
| retire_tag | output | ADDR_W | Address of the retiring instruction |
| done | output | 1 | Program finished and pipe empty |
| retired_cnt | output | CNT_W | Retired instruction count |
| cycle_cnt | output | CNT_W | Cycles since reset, frozen after done |

## Verification
Two events can fall in the same cycle. The first is a branch resolving in execute, which restarts fetch. The second is the restarted fetch reading another branch, which must freeze fetch again at once. A further program has a jump whose target is itself a jump, which sets up this overlap. In that program, `ex_cond` stays low so that conditional branches fall through. A third program toggles `ex_cond` from a pseudo-random sequence in every cycle. This places toggles both inside and outside branch execute cycles. A behavioural model tracks bubble counts and redirect addresses and is compared with every output on every clock. This makes any extra fetch, missing bubble or wrong redirect visible in the cycle where it happens.

// File: rtl/bsp_pkg.sv
package bsp_pkg;

  localparam logic [1:0] CLS_PLAIN = 2'b00;
  localparam logic [1:0] CLS_CBR   = 2'b01;
  localparam logic [1:0] CLS_JMP   = 2'b10;
  localparam logic [1:0] CLS_END   = 2'b11;

  function automatic logic is_branch(input logic [1:0] c);
    return (c == CLS_CBR) || (c == CLS_JMP);
  endfunction

endpackage

// File: rtl/bsp_fetch_ctl.sv
module bsp_fetch_ctl #(
  parameter int ADDR_W     = 8,
  parameter int START_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        imem_cls,
  input  logic              hold_req,
  input  logic              redirect_valid,
  input  logic [ADDR_W-1:0] redirect_addr,
  output logic              f_valid,
  output logic [ADDR_W-1:0] f_tag,
  output logic              halted
);
  import bsp_pkg::*;

  localparam logic [ADDR_W-1:0] START = ADDR_W'(START_ADDR);

  logic [ADDR_W-1:0] pc;
  logic              br_now;
  logic              end_now;

  assign br_now  = f_valid && is_branch(imem_cls);
  assign end_now = f_valid && (imem_cls == CLS_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_valid <= 1'b0;
      f_tag   <= START;
      pc      <= START;
      halted  <= 1'b0;
    end else begin
      halted <= halted | end_now;
      if (redirect_valid) begin
        f_valid <= 1'b1;
        f_tag   <= redirect_addr;
        pc      <= redirect_addr + ADDR_W'(1);
      end else if (halted || end_now || br_now || hold_req) begin
        f_valid <= 1'b0;
      end else begin
        f_valid <= 1'b1;
        f_tag   <= pc;
        pc      <= pc + ADDR_W'(1);
      end
    end
  end

endmodule

// File: rtl/bsp_branch_unit.sv
module bsp_branch_unit #(
  parameter int ADDR_W = 8
) (
  input  logic              ex_valid,
  input  logic [1:0]        ex_cls,
  input  logic [ADDR_W-1:0] ex_tag,
  input  logic [ADDR_W-1:0] ex_tgt,
  input  logic              ex_cond,
  output logic              redirect_valid,
  output logic [ADDR_W-1:0] redirect_addr
);
  import bsp_pkg::*;

  logic taken;

  always_comb begin
    taken          = (ex_cls == CLS_JMP) || ((ex_cls == CLS_CBR) && ex_cond);
    redirect_valid = ex_valid && is_branch(ex_cls);
    redirect_addr  = taken ? ex_tgt : (ex_tag + ADDR_W'(1));
  end

endmodule

// File: rtl/bsp_stage_chain.sv
module bsp_stage_chain #(
  parameter int ADDR_W  = 8,
  parameter int NUM_STG = 5,
  parameter int EX_STG  = 3
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            f_valid,
  input  logic [ADDR_W-1:0]               f_tag,
  input  logic [1:0]                      f_cls,
  input  logic [ADDR_W-1:0]               f_tgt,
  output logic [NUM_STG-1:1]              valid_o,
  output logic [(NUM_STG-1)*ADDR_W-1:0]   tags_o,
  output logic                            ex_valid,
  output logic [1:0]                      ex_cls,
  output logic [ADDR_W-1:0]               ex_tag,
  output logic [ADDR_W-1:0]               ex_tgt,
  output logic                            branch_pending
);
  import bsp_pkg::*;

  logic [NUM_STG-1:1] v;
  logic [ADDR_W-1:0]  tag [1:NUM_STG-1];
  logic [1:0]         cls [1:NUM_STG-1];
  logic [ADDR_W-1:0]  tgt [1:NUM_STG-1];
  logic [NUM_STG-1:1] pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      v[1]   <= 1'b0;
      tag[1] <= '0;
      cls[1] <= CLS_PLAIN;
      tgt[1] <= '0;
    end else begin
      v[1]   <= f_valid;
      tag[1] <= f_tag;
      cls[1] <= f_valid ? f_cls : CLS_PLAIN;
      tgt[1] <= f_tgt;
    end
  end

  for (genvar k = 2; k < NUM_STG; k++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        v[k]   <= 1'b0;
        tag[k] <= '0;
        cls[k] <= CLS_PLAIN;
        tgt[k] <= '0;
      end else begin
        v[k]   <= v[k-1];
        tag[k] <= tag[k-1];
        cls[k] <= cls[k-1];
        tgt[k] <= tgt[k-1];
      end
    end
  end

  for (genvar k = 1; k < NUM_STG; k++) begin : g_out
    assign tags_o[(k-1)*ADDR_W +: ADDR_W] = tag[k];
    if (k < EX_STG) begin : g_pend
      assign pend[k] = v[k] && is_branch(cls[k]);
    end else begin : g_nopend
      assign pend[k] = 1'b0;
    end
  end

  assign valid_o        = v;
  assign branch_pending = |pend;
  assign ex_valid       = v[EX_STG];
  assign ex_cls         = cls[EX_STG];
  assign ex_tag         = tag[EX_STG];
  assign ex_tgt         = tgt[EX_STG];

endmodule

// File: rtl/bsp_progress.sv
module bsp_progress #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             halted,
  input  logic             any_valid,
  input  logic             wo_enter,
  output logic [CNT_W-1:0] retired_cnt,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic             done
);

  always_ff @(posedge clk) begin
    if (rst) begin
      retired_cnt <= '0;
      cycle_cnt   <= '0;
      done        <= 1'b0;
    end else begin
      retired_cnt <= retired_cnt + CNT_W'(wo_enter);
      cycle_cnt   <= cycle_cnt + CNT_W'(!done);
      done        <= done | (halted && !any_valid);
    end
  end

endmodule

// File: rtl/branch_stall_pipe.sv
module branch_stall_pipe #(
  parameter int ADDR_W     = 8,
  parameter int CNT_W      = 16,
  parameter int START_ADDR = 0,
  parameter int NUM_STG    = 5,
  parameter int EX_STG     = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  output logic [ADDR_W-1:0]           imem_addr,
  input  logic [1:0]                  imem_cls,
  input  logic [ADDR_W-1:0]           imem_tgt,
  input  logic                        ex_cond,
  output logic [NUM_STG-1:0]          stg_valid,
  output logic [NUM_STG*ADDR_W-1:0]   stg_tag,
  output logic                        retire,
  output logic [ADDR_W-1:0]           retire_tag,
  output logic                        done,
  output logic [CNT_W-1:0]            retired_cnt,
  output logic [CNT_W-1:0]            cycle_cnt
);

  localparam int LAST = NUM_STG - 1;

  logic                          f_valid;
  logic [ADDR_W-1:0]             f_tag;
  logic                          halted;
  logic                          redirect_valid;
  logic [ADDR_W-1:0]             redirect_addr;
  logic [NUM_STG-1:1]            chain_v;
  logic [(NUM_STG-1)*ADDR_W-1:0] chain_tags;
  logic                          ex_valid;
  logic [1:0]                    ex_cls;
  logic [ADDR_W-1:0]             ex_tag;
  logic [ADDR_W-1:0]             ex_tgt;
  logic                          branch_pending;

  bsp_fetch_ctl #(.ADDR_W(ADDR_W), .START_ADDR(START_ADDR)) u_fetch (
    .clk            (clk),
    .rst            (rst),
    .imem_cls       (imem_cls),
    .hold_req       (branch_pending),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr),
    .f_valid        (f_valid),
    .f_tag          (f_tag),
    .halted         (halted)
  );

  bsp_stage_chain #(.ADDR_W(ADDR_W), .NUM_STG(NUM_STG), .EX_STG(EX_STG)) u_chain (
    .clk            (clk),
    .rst            (rst),
    .f_valid        (f_valid),
    .f_tag          (f_tag),
    .f_cls          (imem_cls),
    .f_tgt          (imem_tgt),
    .valid_o        (chain_v),
    .tags_o         (chain_tags),
    .ex_valid       (ex_valid),
    .ex_cls         (ex_cls),
    .ex_tag         (ex_tag),
    .ex_tgt         (ex_tgt),
    .branch_pending (branch_pending)
  );

  bsp_branch_unit #(.ADDR_W(ADDR_W)) u_branch (
    .ex_valid       (ex_valid),
    .ex_cls         (ex_cls),
    .ex_tag         (ex_tag),
    .ex_tgt         (ex_tgt),
    .ex_cond        (ex_cond),
    .redirect_valid (redirect_valid),
    .redirect_addr  (redirect_addr)
  );

  bsp_progress #(.CNT_W(CNT_W)) u_prog (
    .clk         (clk),
    .rst         (rst),
    .halted      (halted),
    .any_valid   (f_valid || (|chain_v)),
    .wo_enter    (chain_v[LAST-1]),
    .retired_cnt (retired_cnt),
    .cycle_cnt   (cycle_cnt),
    .done        (done)
  );

  assign imem_addr  = f_tag;
  assign stg_valid  = {chain_v, f_valid};
  assign stg_tag    = {chain_tags, f_tag};
  assign retire     = chain_v[LAST];
  assign retire_tag = chain_tags[(LAST-1)*ADDR_W +: ADDR_W];

endmodule

// File: rtl/bsp_pipe_chk.sv
module bsp_pipe_chk #(
  parameter int ADDR_W  = 8,
  parameter int CNT_W   = 16,
  parameter int NUM_STG = 5
) (
  input logic                      clk,
  input logic                      rst,
  input logic [1:0]                imem_cls,
  input logic [NUM_STG-1:0]        stg_valid,
  input logic [NUM_STG*ADDR_W-1:0] stg_tag,
  input logic                      retire,
  input logic                      done,
  input logic [CNT_W-1:0]          cycle_cnt
);

  logic br_fetch;
  assign br_fetch = stg_valid[0] && (imem_cls == 2'b01 || imem_cls == 2'b10);

  for (genvar k = 1; k < NUM_STG; k++) begin : g_adv
    // R2
    adv_valid_chk: assert property (@(posedge clk) disable iff (rst)
      stg_valid[k] == $past(stg_valid[k-1]));
    // R2
    adv_tag_chk: assert property (@(posedge clk) disable iff (rst)
      stg_valid[k] |-> stg_tag[k*ADDR_W +: ADDR_W] == $past(stg_tag[(k-1)*ADDR_W +: ADDR_W]));
  end

  // R3
  bubble_a_chk: assert property (@(posedge clk) disable iff (rst)
    br_fetch |=> !stg_valid[0]);
  // R3
  bubble_b_chk: assert property (@(posedge clk) disable iff (rst)
    $past(br_fetch) |=> !stg_valid[0]);
  // R3
  bubble_c_chk: assert property (@(posedge clk) disable iff (rst)
    $past(br_fetch, 2) |=> !stg_valid[0]);
  // R4
  resume_chk: assert property (@(posedge clk) disable iff (rst)
    $past(br_fetch, 3) |=> stg_valid[0]);
  // R7
  retire_src_chk: assert property (@(posedge clk) disable iff (rst)
    retire |-> $past(stg_valid[NUM_STG-2]));
  // R8
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R8
  done_empty_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> stg_valid == '0);
  // R9
  cycle_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(done)) |-> cycle_cnt == $past(cycle_cnt) + CNT_W'(1));

endmodule

bind branch_stall_pipe bsp_pipe_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NUM_STG(NUM_STG)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .imem_cls  (imem_cls),
  .stg_valid (stg_valid),
  .stg_tag   (stg_tag),
  .retire    (retire),
  .done      (done),
  .cycle_cnt (cycle_cnt)
);

// File: tb/test_branch_stall_pipe.sv
`timescale 1ns/100ps
module test_branch_stall_pipe;

  localparam int AW = 8;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] imem_addr;
  logic [1:0]    imem_cls;
  logic [AW-1:0] imem_tgt;
  logic          ex_cond = 1'b0;
  logic [4:0]    stg_valid;
  logic [5*AW-1:0] stg_tag;
  logic          retire;
  logic [AW-1:0] retire_tag;
  logic          done;
  logic [CW-1:0] retired_cnt;
  logic [CW-1:0] cycle_cnt;

  logic [1:0]    rom_cls [256];
  logic [AW-1:0] rom_tgt [256];

  int n_chk = 0;
  int n_fail = 0;
  int cond_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  // reference model state
  int m_v[5], m_a[5], m_c[5], m_t[5];
  int m_pc, m_wait, m_halt, m_done, m_cyc, m_ret, br_a, br_c, br_t;
  int o_v0, o_a0, o_c, empty;

  int fq[$];
  int bub_mask, last_cyc, last_tag, n_ret_seen;

  always #2.5 clk = ~clk;

  assign imem_cls = rom_cls[imem_addr];
  assign imem_tgt = rom_tgt[imem_addr];

  branch_stall_pipe i_branch_stall_pipe (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_cls(imem_cls),
    .imem_tgt(imem_tgt), .ex_cond(ex_cond), .stg_valid(stg_valid),
    .stg_tag(stg_tag), .retire(retire), .retire_tag(retire_tag),
    .done(done), .retired_cnt(retired_cnt), .cycle_cnt(cycle_cnt)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    case (cond_mode)
      0: ex_cond <= 1'b0;
      1: ex_cond <= 1'b1;
      default: begin
        lfsr    <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        ex_cond <= lfsr[0];
      end
    endcase
  end

  // behavioural reference: bubble countdown after a fetched branch
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 5; k++) begin m_v[k] = 0; m_a[k] = 0; m_c[k] = 0; m_t[k] = 0; end
      m_pc = 0; m_wait = 0; m_halt = 0; m_done = 0; m_cyc = 0; m_ret = 0;
    end else begin
      o_v0 = m_v[0]; o_a0 = m_a[0]; o_c = int'(rom_cls[o_a0]);
      empty = 1;
      for (int k = 0; k < 5; k++) if (m_v[k] != 0) empty = 0;
      if (m_done == 0) m_cyc++;
      if (m_halt != 0 && empty != 0) m_done = 1;
      if (m_v[3] != 0) m_ret++;
      for (int k = 4; k > 1; k--) begin
        m_v[k] = m_v[k-1]; m_a[k] = m_a[k-1]; m_c[k] = m_c[k-1]; m_t[k] = m_t[k-1];
      end
      m_v[1] = o_v0; m_a[1] = o_a0; m_c[1] = o_c; m_t[1] = int'(rom_tgt[o_a0]);
      if (m_wait > 1) begin
        m_wait--; m_v[0] = 0;
      end else if (m_wait == 1) begin
        m_wait = 0; m_v[0] = 1;
        if (br_c == 2 || (br_c == 1 && ex_cond)) m_a[0] = br_t;
        else m_a[0] = (br_a + 1) & 255;
        m_pc = (m_a[0] + 1) & 255;
      end else if (m_halt != 0) begin
        m_v[0] = 0;
      end else if (o_v0 != 0 && (o_c == 1 || o_c == 2)) begin
        m_wait = 3; br_a = o_a0; br_c = o_c; br_t = int'(rom_tgt[o_a0]); m_v[0] = 0;
      end else if (o_v0 != 0 && o_c == 3) begin
        m_halt = 1; m_v[0] = 0;
      end else begin
        m_v[0] = 1; m_a[0] = m_pc; m_pc = (m_pc + 1) & 255;
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      for (int k = 0; k < 5; k++) begin
        chk(stg_valid[k] == (m_v[k] != 0), "R2 R3 R4 R5 R6 valid", stg_valid[k], m_v[k]);
        if (m_v[k] != 0)
          chk(int'(stg_tag[k*AW +: AW]) == m_a[k], "R2 R4 R5 R6 tag", stg_tag[k*AW +: AW], m_a[k]);
      end
      chk(retire == (m_v[4] != 0), "R7 retire", retire, m_v[4]);
      if (retire) chk(int'(retire_tag) == m_a[4], "R7 retire_tag", retire_tag, m_a[4]);
      chk(int'(retired_cnt) == m_ret, "R7 count", retired_cnt, m_ret);
      chk(done == (m_done != 0), "R8 done", done, m_done);
      chk(int'(cycle_cnt) == m_cyc, "R9 cycle", cycle_cnt, m_cyc);
      if (stg_valid[0]) fq.push_back(int'(imem_addr));
      if (!stg_valid[0] && cycle_cnt >= 1 && cycle_cnt <= 11) bub_mask |= (1 << cycle_cnt);
      if (retire) begin last_cyc = int'(cycle_cnt); last_tag = int'(retire_tag); n_ret_seen++; end
    end
  end

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) begin rom_cls[i] = 2'b00; rom_tgt[i] = '0; end
  endtask

  task automatic run_prog(input int cmode);
    int guard;
    @(negedge clk);
    rst = 1'b1;
    cond_mode = cmode;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(stg_valid == 5'b0, "R1 valid", stg_valid, 0);
    chk(done == 1'b0 && retire == 1'b0, "R1 done/retire", {done, retire}, 0);
    chk(retired_cnt == '0 && cycle_cnt == '0, "R1 counters", cycle_cnt, 0);
    fq.delete(); bub_mask = 0; n_ret_seen = 0; last_cyc = 0; last_tag = 0;
    rst = 1'b0;
    @(negedge clk);
    chk(stg_valid[0] && imem_addr == '0 && cycle_cnt == 1, "R1 first fetch", imem_addr, 0);
    guard = 0;
    while (!done && guard < 300) begin
      @(negedge clk);
      guard++;
    end
    if (!done) chk(1'b0, "watchdog", guard, 300);
  endtask

  initial begin
    int cyc_at_done;
    // program 1: twelve words, taken branch at address 3 to address 8
    clear_rom();
    rom_cls[3] = 2'b01; rom_tgt[3] = 8'd8;
    rom_cls[11] = 2'b11;
    run_prog(1);
    chk(last_cyc == 15 && last_tag == 11, "R9 last retire cycle", last_cyc, 15);
    $display("program 1: %0d cycles x 11 ns = %0d ns", last_cyc, last_cyc * 11);
    chk(bub_mask == ((1 << 5) | (1 << 6) | (1 << 7)), "R3 bubble cycles", bub_mask, 224);
    chk(fq.size() == 8 && fq[3] == 3 && fq[4] == 8 && fq[7] == 11, "R4 fetch order", fq.size(), 8);
    chk(retired_cnt == 8, "R7 total", retired_cnt, 8);
    cyc_at_done = int'(cycle_cnt);
    repeat (3) @(negedge clk);
    chk(done && int'(cycle_cnt) == cyc_at_done, "R8 hold", cycle_cnt, cyc_at_done);
    chk(stg_valid == 5'b0, "R8 no fetch after end", stg_valid, 0);

    // program 2: not-taken branches and a jump landing on a jump
    clear_rom();
    rom_cls[1] = 2'b01; rom_tgt[1] = 8'd20;
    rom_cls[2] = 2'b10; rom_tgt[2] = 8'd5;
    rom_cls[5] = 2'b01; rom_tgt[5] = 8'd9;
    rom_cls[6] = 2'b10; rom_tgt[6] = 8'd12;
    rom_cls[12] = 2'b10; rom_tgt[12] = 8'd14;
    rom_cls[14] = 2'b11;
    run_prog(0);
    chk(fq.size() == 7 && fq[2] == 2 && fq[4] == 6 && fq[5] == 12 && fq[6] == 14,
        "R5 fall-through order", fq.size(), 7);
    chk(retired_cnt == 7, "R7 total 2", retired_cnt, 7);

    // program 3: condition toggles every cycle
    clear_rom();
    rom_cls[1] = 2'b01; rom_tgt[1] = 8'd6;
    rom_cls[3] = 2'b01; rom_tgt[3] = 8'd7;
    rom_cls[6] = 2'b01; rom_tgt[6] = 8'd8;
    rom_cls[7] = 2'b10; rom_tgt[7] = 8'd9;
    rom_cls[9] = 2'b01; rom_tgt[9] = 8'd11;
    rom_cls[11] = 2'b11;
    run_prog(2);
    chk(int'(retired_cnt) == fq.size() && n_ret_seen == fq.size(), "R10 all fetched retire",
        retired_cnt, fq.size());
    chk(done, "R6 R8 random condition completes", done, 1);

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule